// File: doc/BRIEF.md
# Two-Bank Interrupt Controller with Fast-Interrupt Routing

This block gathers 64 level-sensitive peripheral interrupt lines, split into a low bank (lines 0-31) and a high bank (lines 32-63), and 8 local interrupt lines. It combines them into one normal interrupt request output and one fast interrupt output. Each line has an enable bit. Software never writes an enable mask directly. It sets bits through a set-enable register and clears bits through a matching clear-enable register, so concurrent owners of different lines never need a read-modify-write.

The normal request output is the OR of every line that is both asserted and enabled. The fast output follows exactly one raw input line, chosen by a 7-bit index that spans both peripheral banks and the local group. That line is taken as it is, whatever the enable masks hold. A summary register lets a handler triage in one read. It packs the enabled local lines, an "any pending" flag per peripheral bank, and eleven frequently used peripheral lines mirrored at fixed bit positions.

Access is through a plain 32-bit register bus with a valid strobe, write enable, byte address, write data and registered read data. Only aligned whole-word accesses are decoded.

Top module: `dual_bank_intc`

## Requirements
- R1: Reset (synchronous, active high) clears all three enable masks, the fast-interrupt enable and the fast-interrupt index. Both outputs are low after reset.
- R2: A write to a set-enable word ORs the written bits into the mask: offset 0x10 for low-bank lines 0-31, 0x14 for high-bank lines 32-63 (bit n = line 32+n), and 0x18 for local lines. For the local group only write-data bits 7:0 matter.
- R3: A write to a clear-enable word clears every mask bit written as 1 and leaves the others: offset 0x1C for the low bank, 0x20 for the high bank and 0x24 for the local group.
- R4: A read of a set-enable word returns the mask, zero-extended to 32 bits. A read of the matching clear-enable word returns the bitwise inverse of that zero-extended value, so the local clear-enable word reads with bits 31:8 all ones.
- R5: Offset 0x04 reads the low-bank input levels ANDed with the low-bank mask. Offset 0x08 does the same for the high bank.
- R6: Offset 0x00 reads the summary word. Bits 7:0 hold local inputs ANDed with the local mask. Bit 8 is set if any enabled low-bank line is asserted, and bit 9 if any enabled high-bank line is asserted. Bits 10 to 20 carry the enabled pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order. Bits 31:21 read zero.
- R7: Offset 0x0C is the fast-interrupt control word. Bits 6:0 hold the index and bit 7 the enable. A write loads both, a read returns them in the same positions, and bits 31:8 are ignored on write and read as zero.
- R8: With fast interrupts enabled, an index below 64 routes that peripheral input, 64 to 71 route local input (index-64), and 72 or more give a low output. The enable masks play no part. With fast interrupts disabled the output is low.
- R9: The normal interrupt output is high exactly when some peripheral or local input is asserted while its enable bit is set.
- R10: Both outputs are registered. A change of an input, a mask or the fast-interrupt control word appears on the outputs at the clock edge after the change takes effect. Read data appears at the clock edge that samples the read strobe.
- R11: Reads of undecoded offsets (0x28 and up, or any address with bits 1:0 non-zero) return zero. Writes to such offsets, or to the pending and summary words, change no state.
- R12: Inputs are levels with no latching. A line that drops immediately leaves the pending words, the summary and the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq | input | 64 | Peripheral interrupt levels, lines 0-63 |
| local_irq | input | 8 | Local interrupt levels |
| bus_valid | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address within the 0x200 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
Sparse peripheral patterns drive lines 0, 3, 7, 10 and 62 together with several local patterns. Each enable write then separates OR-into-mask from overwrite and clear-only-ones from clear-all, and each pending read separates masked from raw levels. The summary is read with a mirrored line enabled and then disabled, and again after a line drops, which shows that the mirror bits and the bank flags are independent and live. Fast-interrupt indices in both banks, at the local base, past the last local line and with enable off show that routing ignores the masks and that the range limit holds. Outputs are sampled both before and after the clock edge that follows a change, which pins down the single register stage.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [3:0] {
    RS_SUMMARY  = 4'd0,
    RS_PEND_LO  = 4'd1,
    RS_PEND_HI  = 4'd2,
    RS_FIQ      = 4'd3,
    RS_SET_LO   = 4'd4,
    RS_SET_HI   = 4'd5,
    RS_SET_LOC  = 4'd6,
    RS_CLR_LO   = 4'd7,
    RS_CLR_HI   = 4'd8,
    RS_CLR_LOC  = 4'd9,
    RS_NONE     = 4'd10
  } reg_sel_e;

  localparam int N_MIRROR = 11;

  // peripheral line shown at summary mirror slot i (slot order is fixed)
  function automatic int mirror_line(input int i);
    case (i)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      10:      return 62;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic              aligned;
  logic [ADDR_W-3:0] word;

  assign aligned = (addr[1:0] == 2'b00);
  assign word    = addr[ADDR_W-1:2];

  always_comb begin
    sel = RS_NONE;
    if (aligned) begin
      case (int'(word))
        0:       sel = RS_SUMMARY;
        1:       sel = RS_PEND_LO;
        2:       sel = RS_PEND_HI;
        3:       sel = RS_FIQ;
        4:       sel = RS_SET_LO;
        5:       sel = RS_SET_HI;
        6:       sel = RS_SET_LOC;
        7:       sel = RS_CLR_LO;
        8:       sel = RS_CLR_HI;
        9:       sel = RS_CLR_LOC;
        default: sel = RS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/intc_enable_bank.sv
module intc_enable_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (set_stb) begin
      mask <= mask | wdata;
    end else if (clr_stb) begin
      mask <= mask & ~wdata;
    end
  end

  // R2: every bit written to the set word is on afterwards
  a_r2_set_bits_on: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((mask & $past(wdata)) == $past(wdata)));

  // R3: every bit written to the clear word is off afterwards
  a_r3_clear_bits_off: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((mask & $past(wdata)) == '0));

  // R3: bits not written as one survive a clear
  a_r3_clear_keeps_rest: assert property (@(posedge clk) disable iff (rst)
    (clr_stb && !set_stb) |=> ((mask | $past(wdata)) == ($past(mask) | $past(wdata))));
endmodule

// File: rtl/intc_fiq_route.sv
module intc_fiq_route #(
  parameter int NP    = 64,
  parameter int NL    = 8,
  parameter int IDX_W = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_stb,
  input  logic [IDX_W:0] wdata,
  input  logic [NP-1:0]  periph,
  input  logic [NL-1:0]  locl,
  output logic [IDX_W:0] ctrl,
  output logic           fiq_out
);
  localparam int PW = $clog2(NP);
  localparam int LW = $clog2(NL);
  localparam logic [IDX_W-1:0] LOC_BASE = IDX_W'(NP);
  localparam logic [IDX_W-1:0] LOC_END  = IDX_W'(NP + NL);

  logic [IDX_W-1:0] idx_q;
  logic             en_q;
  logic [IDX_W-1:0] loc_off;
  logic             sel_level;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_stb) begin
      idx_q <= wdata[IDX_W-1:0];
      en_q  <= wdata[IDX_W];
    end
  end

  assign loc_off = idx_q - LOC_BASE;

  always_comb begin
    if (idx_q < LOC_BASE) begin
      sel_level = periph[idx_q[PW-1:0]];
    end else if (idx_q < LOC_END) begin
      sel_level = locl[loc_off[LW-1:0]];
    end else begin
      sel_level = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fiq_out <= 1'b0;
    end else begin
      fiq_out <= en_q & sel_level;
    end
  end

  assign ctrl = {en_q, idx_q};

  // R8: disabled routing keeps the output low
  a_r8_fiq_low_when_off: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !fiq_out);

  // R8: an index past the last local line yields nothing
  a_r8_fiq_low_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (idx_q >= LOC_END) |=> !fiq_out);

  // R8: a peripheral index follows that raw input one edge later
  a_r8_fiq_follows_periph: assert property (@(posedge clk) disable iff (rst)
    (en_q && idx_q < LOC_BASE) |=> (fiq_out == $past(periph[idx_q[PW-1:0]])));
endmodule

// File: rtl/intc_summary.sv
module intc_summary
  import intc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NL     = 8
) (
  input  logic [DATA_W-1:0] pend_lo,
  input  logic [DATA_W-1:0] pend_hi,
  input  logic [NL-1:0]     pend_loc,
  output logic [DATA_W-1:0] summary
);
  localparam int FLAG_LO  = NL;
  localparam int FLAG_HI  = NL + 1;
  localparam int MIR_BASE = NL + 2;

  logic [2*DATA_W-1:0] pend_all;
  assign pend_all = {pend_hi, pend_lo};

  always_comb begin
    summary           = '0;
    summary[NL-1:0]   = pend_loc;
    summary[FLAG_LO]  = |pend_lo;
    summary[FLAG_HI]  = |pend_hi;
    for (int i = 0; i < N_MIRROR; i++) begin
      summary[MIR_BASE + i] = pend_all[mirror_line(i)];
    end
  end
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
  import intc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_LOCAL = 8,
  parameter int FIQ_IDX_W = 7,
  parameter int ADDR_W    = 9
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [2*DATA_W-1:0]    periph_irq,
  input  logic [NUM_LOCAL-1:0]   local_irq,
  input  logic                   bus_valid,
  input  logic                   bus_we,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  output logic                   irq_out,
  output logic                   fiq_out
);
  localparam int NUM_PERIPH = 2 * DATA_W;
  localparam int NUM_BANKS  = 2;

  reg_sel_e                 sel;
  logic                     wr, rd;
  logic [NUM_BANKS-1:0]     bank_set, bank_clr;
  logic [DATA_W-1:0]        bank_mask [NUM_BANKS];
  logic [DATA_W-1:0]        bank_pend [NUM_BANKS];
  logic [NUM_LOCAL-1:0]     loc_mask;
  logic [NUM_LOCAL-1:0]     loc_pend;
  logic [DATA_W-1:0]        loc_mask_ext;
  logic [DATA_W-1:0]        summary;
  logic [FIQ_IDX_W:0]       fiq_ctrl;
  logic [DATA_W-1:0]        rd_next;

  intc_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr = bus_valid & bus_we;
  assign rd = bus_valid & ~bus_we;

  assign bank_set[0] = wr && (sel == RS_SET_LO);
  assign bank_set[1] = wr && (sel == RS_SET_HI);
  assign bank_clr[0] = wr && (sel == RS_CLR_LO);
  assign bank_clr[1] = wr && (sel == RS_CLR_HI);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    intc_enable_bank #(.W(DATA_W)) i_bank (
      .clk     (clk),
      .rst     (rst),
      .set_stb (bank_set[b]),
      .clr_stb (bank_clr[b]),
      .wdata   (bus_wdata),
      .mask    (bank_mask[b])
    );
    assign bank_pend[b] = periph_irq[b*DATA_W +: DATA_W] & bank_mask[b];
  end

  intc_enable_bank #(.W(NUM_LOCAL)) i_local_bank (
    .clk     (clk),
    .rst     (rst),
    .set_stb (wr && (sel == RS_SET_LOC)),
    .clr_stb (wr && (sel == RS_CLR_LOC)),
    .wdata   (bus_wdata[NUM_LOCAL-1:0]),
    .mask    (loc_mask)
  );

  assign loc_pend     = local_irq & loc_mask;
  assign loc_mask_ext = {{(DATA_W-NUM_LOCAL){1'b0}}, loc_mask};

  intc_fiq_route #(
    .NP    (NUM_PERIPH),
    .NL    (NUM_LOCAL),
    .IDX_W (FIQ_IDX_W)
  ) i_fiq (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (wr && (sel == RS_FIQ)),
    .wdata   (bus_wdata[FIQ_IDX_W:0]),
    .periph  (periph_irq),
    .locl    (local_irq),
    .ctrl    (fiq_ctrl),
    .fiq_out (fiq_out)
  );

  intc_summary #(.DATA_W(DATA_W), .NL(NUM_LOCAL)) i_summary (
    .pend_lo  (bank_pend[0]),
    .pend_hi  (bank_pend[1]),
    .pend_loc (loc_pend),
    .summary  (summary)
  );

  always_comb begin
    case (sel)
      RS_SUMMARY: rd_next = summary;
      RS_PEND_LO: rd_next = bank_pend[0];
      RS_PEND_HI: rd_next = bank_pend[1];
      RS_FIQ:     rd_next = {{(DATA_W-FIQ_IDX_W-1){1'b0}}, fiq_ctrl};
      RS_SET_LO:  rd_next = bank_mask[0];
      RS_SET_HI:  rd_next = bank_mask[1];
      RS_SET_LOC: rd_next = loc_mask_ext;
      RS_CLR_LO:  rd_next = ~bank_mask[0];
      RS_CLR_HI:  rd_next = ~bank_mask[1];
      RS_CLR_LOC: rd_next = ~loc_mask_ext;
      default:    rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      bus_rdata <= rd_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= 1'b0;
    end else begin
      irq_out <= (|bank_pend[0]) | (|bank_pend[1]) | (|loc_pend);
    end
  end

  // R9: with every mask empty the request stays low
  a_r9_irq_low_without_enables: assert property (@(posedge clk) disable iff (rst)
    (bank_mask[0] == '0 && bank_mask[1] == '0 && loc_mask == '0) |=> !irq_out);

  // R9: an enabled, asserted local line raises the request
  a_r9_irq_high_on_local: assert property (@(posedge clk) disable iff (rst)
    ((local_irq & loc_mask) != '0) |=> irq_out);

  // R11: undecoded reads return zero
  a_r11_unmapped_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == RS_NONE) |=> (bus_rdata == '0));

  // R5: low-bank pending read equals masked input levels
  a_r5_pending_low_read: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == RS_PEND_LO) |=> (bus_rdata == $past(periph_irq[DATA_W-1:0] & bank_mask[0])));
endmodule

// File: tb/test_dual_bank_intc.sv
module test_dual_bank_intc;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] periph_irq = '0;
  logic [7:0]  local_irq = '0;
  logic        bus_valid = 1'b0;
  logic        bus_we = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  typedef struct {
    logic [8:0]  addr;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  dual_bank_intc i_dual_bank_intc (
    .clk, .rst, .periph_irq, .local_irq, .bus_valid, .bus_we,
    .bus_addr, .bus_wdata, .bus_rdata, .irq_out, .fiq_out
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: pops one expected item per read that the design sampled
  initial begin
    forever begin
      bit fired;
      @(posedge clk);
      fired = bus_valid && !bus_we;
      @(negedge clk);
      if (fired && sb_q.size() > 0) begin
        rd_item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (bus_rdata !== it.exp) begin
          n_bad++;
          $display("FAIL %s: read 0x%03h got 0x%08h expected 0x%08h",
                   it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [8:0] a, input logic [31:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    bus_valid = 1; bus_we = 0; bus_addr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic set_in(input logic [63:0] p, input logic [7:0] l);
    @(negedge clk);
    periph_irq = p; local_irq = l;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chk_pin(input string tag, input logic got, input logic e);
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, got, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_pin("R1 irq after reset", irq_out, 0);
    chk_pin("R1 fiq after reset", fiq_out, 0);
    bus_rd(9'h010, 32'h0, "R1 low mask");
    bus_rd(9'h014, 32'h0, "R1 high mask");
    bus_rd(9'h018, 32'h0, "R1 local mask");
    bus_rd(9'h00C, 32'h0, "R1 fiq control");
    bus_rd(9'h01C, 32'hFFFF_FFFF, "R4 low clear word at reset");
    bus_rd(9'h024, 32'hFFFF_FFFF, "R4 local clear word at reset");

    // inputs with every mask empty
    set_in(64'h4000_0000_0000_0481, 8'h07);
    settle();
    chk_pin("R9 no enables", irq_out, 0);
    bus_rd(9'h004, 32'h0, "R5 masked pending");
    bus_rd(9'h000, 32'h0, "R6 empty summary");

    // set / clear low bank
    bus_wr(9'h010, 32'h0000_0480);
    settle();
    chk_pin("R9 enabled line asserted", irq_out, 1);
    bus_rd(9'h010, 32'h0000_0480, "R2 low set");
    bus_rd(9'h004, 32'h0000_0480, "R5 low pending");
    bus_wr(9'h010, 32'h0000_0001);
    bus_rd(9'h010, 32'h0000_0481, "R2 set ORs");
    bus_wr(9'h01C, 32'h0000_0080);
    bus_rd(9'h010, 32'h0000_0401, "R3 clear ones only");
    bus_rd(9'h01C, 32'hFFFF_FBFE, "R4 low clear word inverse");

    // high bank and local group
    bus_wr(9'h014, 32'h4000_0000);
    bus_rd(9'h008, 32'h4000_0000, "R5 high pending");
    bus_rd(9'h020, 32'hBFFF_FFFF, "R4 high clear word inverse");
    bus_wr(9'h018, 32'hFFFF_FF05);
    bus_rd(9'h018, 32'h0000_0005, "R2 local low byte only");
    bus_rd(9'h024, 32'hFFFF_FFFA, "R4 local clear word inverse");

    // summary layout
    bus_rd(9'h000, 32'h0010_1305, "R6 summary flags and mirrors");
    bus_wr(9'h010, 32'h0000_0080);
    bus_rd(9'h000, 32'h0010_1705, "R6 mirror slot of line 7");
    bus_wr(9'h01C, 32'h0000_0080);
    bus_wr(9'h024, 32'h0000_0004);
    bus_rd(9'h018, 32'h0000_0001, "R3 local clear");

    // R12 level inputs: line 10 drops
    set_in(64'h4000_0000_0000_0081, 8'h07);
    bus_rd(9'h004, 32'h0000_0001, "R12 dropped line leaves pending");
    bus_rd(9'h000, 32'h0010_0301, "R12 dropped line leaves summary");

    // R11 ignored accesses
    bus_wr(9'h004, 32'hFFFF_FFFF);
    bus_wr(9'h000, 32'hFFFF_FFFF);
    bus_wr(9'h040, 32'hFFFF_FFFF);
    bus_wr(9'h011, 32'hFFFF_FFFF);
    bus_rd(9'h010, 32'h0000_0401, "R11 low mask untouched");
    bus_rd(9'h018, 32'h0000_0001, "R11 local mask untouched");
    bus_rd(9'h040, 32'h0, "R11 unmapped read");
    bus_rd(9'h012, 32'h0, "R11 unaligned read");
    bus_rd(9'h1FC, 32'h0, "R11 window top read");

    // R7 / R8 fast interrupt routing
    set_in(64'h4000_0000_0000_0089, 8'h07);
    bus_wr(9'h00C, 32'h0000_0083);
    settle();
    chk_pin("R8 masked line 3 routed", fiq_out, 1);
    bus_rd(9'h00C, 32'h0000_0083, "R7 control readback");
    bus_wr(9'h00C, 32'hFFFF_FF83);
    bus_rd(9'h00C, 32'h0000_0083, "R7 upper bits ignored");
    bus_wr(9'h00C, 32'h0000_00C2);
    settle();
    chk_pin("R8 local index 66", fiq_out, 1);
    set_in(64'h4000_0000_0000_0089, 8'h03);
    settle();
    chk_pin("R12 local line 2 dropped", fiq_out, 0);
    set_in(64'h4000_0000_0000_0089, 8'hFF);
    bus_wr(9'h00C, 32'h0000_00C8);
    settle();
    chk_pin("R8 index 72 out of range", fiq_out, 0);
    bus_wr(9'h00C, 32'h0000_00FF);
    settle();
    chk_pin("R8 index 127 out of range", fiq_out, 0);
    bus_wr(9'h00C, 32'h0000_00BE);
    settle();
    chk_pin("R8 line 62 routed", fiq_out, 1);
    bus_wr(9'h00C, 32'h0000_003E);
    settle();
    chk_pin("R8 disabled", fiq_out, 0);
    bus_rd(9'h00C, 32'h0000_003E, "R7 disabled readback");

    // R10 one register stage
    bus_wr(9'h00C, 32'h0000_00BE);
    chk_pin("R10 fiq before edge", fiq_out, 0);
    settle();
    chk_pin("R10 fiq after edge", fiq_out, 1);
    set_in(64'h0, 8'h00);
    #1;
    chk_pin("R10 irq holds until edge", irq_out, 1);
    chk_pin("R10 fiq holds until edge", fiq_out, 1);
    settle();
    chk_pin("R9 irq low after inputs drop", irq_out, 0);
    chk_pin("R10 fiq low after edge", fiq_out, 0);

    // clear everything
    bus_wr(9'h01C, 32'hFFFF_FFFF);
    bus_wr(9'h020, 32'hFFFF_FFFF);
    bus_wr(9'h024, 32'hFFFF_FFFF);
    bus_rd(9'h010, 32'h0, "R3 low cleared");
    bus_rd(9'h014, 32'h0, "R3 high cleared");
    bus_rd(9'h018, 32'h0, "R3 local cleared");

    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule